// File: doc/BRIEF.md
# Page-Bounded Chained Block Mover

This block copies runs of 32-bit words between a peripheral port and memory with no processor work per word. Software sets a start address and a byte length in two control registers. It then writes a command word that picks the direction and the mode and sets the go bit. Once started, the engine paces every word with a strobe/acknowledge handshake on both sides. It raises a level interrupt when it finishes or when it rejects a segment.

In linked mode the address register instead points at a list of three-word records in memory. Each record describes one segment that must fit inside a single page. This lets a buffer that is contiguous to software sit in scattered physical pages. For every word it stores to memory, the engine emits a one-cycle invalidate notice that carries the written address, so that a cache can drop a stale line. Address translation, caching and bus arbitration are handled outside this block.

Top module: `chain_dma`

## Requirements
- R1: After reset the status reads zero, `irq` is low and neither `mem_req` nor `dev_stb` is asserted.
- R2: A direct transfer with command bit2 = 1 (device to memory) reads `LEN/4` words from the device and stores them at consecutive word addresses from the start address. Each memory request holds its address until acknowledged.
- R3: A direct transfer with command bit2 = 0 (memory to device) reads `LEN/4` consecutive words from the start address and hands them to the device in order.
- R4: Status bit0 (busy) reads 1 during a transfer. A command write with bit0 = 1 while busy is ignored: it adds no transfer and no second completion.
- R5: With command bit1 = 1, the engine fetches records at pointer, pointer+4 and pointer+8. Word 0 is the segment address. Word 1 holds the direction in bit31 (1 = device to memory) and the byte length in its low bits. Word 2 is the next pointer. A next pointer of zero ends the list.
- R6: In linked mode, a segment whose page offset plus length exceeds `PAGE_BYTES` sets status bit2 (error), stops the list and makes no access for that segment. A segment ending exactly at a page boundary is accepted.
- R7: A length of zero words in either mode sets the error bit and makes no data access.
- R8: Each accepted memory write is followed on the next cycle by a one-cycle `inv_valid` carrying the same address.
- R9: Successful completion sets status bit1 (done). `irq` equals done OR error and stays high until software writes 1 to those bits of the status register (CSR index 3).
- R10: CSR indices are: 0 command (bit0 go, bit1 linked, bit2 device-to-memory), 1 address or list pointer, 2 byte length, 3 status. Reads return data one cycle after `csr_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | 2 | Register word index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid one cycle after `csr_re` |
| irq | output | 1 | Level interrupt: done or error |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Memory read data |
| dev_stb | output | 1 | Peripheral word strobe, held until `dev_ack` |
| dev_we | output | 1 | Strobe carries data toward the peripheral |
| dev_wdata | output | 32 | Data toward the peripheral |
| dev_ack | input | 1 | Peripheral accepts or supplies a word |
| dev_rdata | input | 32 | Data from the peripheral |
| inv_valid | output | 1 | Cache invalidate notice |
| inv_addr | output | 32 | Address to invalidate |

## Verification
The invalidate notice is due exactly one cycle after the edge that accepts a memory write. The bench compares each notice, in order, with the log of memory writes taken by its memory model. Done, error and `irq` rise two edges after the handshake that ends the last word or the rejected record. Register reads land one edge after the strobe. The bench therefore waits for `irq` with a bounded poll on falling edges and only then reads status and memory. An interrupt clear is checked at the falling edge right after the status write, because `irq` updates on that same edge.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 20;          // byte-length field width
  localparam int WCNT_W = LEN_W - 2;   // word-count width

  localparam logic [1:0] CSR_CMD  = 2'd0;
  localparam logic [1:0] CSR_ADDR = 2'd1;
  localparam logic [1:0] CSR_LEN  = 2'd2;
  localparam logic [1:0] CSR_STAT = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DESC, ST_CHECK, ST_DEV_RD, ST_MEM_WR,
    ST_MEM_RD, ST_DEV_WR, ST_NEXT
  } xfer_state_e;

  typedef struct packed {
    logic              linked;
    logic              to_mem;
    logic [ADDR_W-1:0] addr;
    logic [WCNT_W-1:0] words;
  } launch_cfg_t;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [1:0]        csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              busy_i,
  input  logic              done_p_i,
  input  logic              err_p_i,
  output logic              go_o,
  output launch_cfg_t       cfg_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [WCNT_W-1:0] words_q;
  logic              done_q, err_q, done_n, err_n;
  logic              stat_wr;

  assign stat_wr = csr_we && (csr_addr == CSR_STAT);
  assign go_o    = csr_we && (csr_addr == CSR_CMD) && csr_wdata[0];

  assign cfg_o.linked = csr_wdata[1];
  assign cfg_o.to_mem = csr_wdata[2];
  assign cfg_o.addr   = addr_q;
  assign cfg_o.words  = words_q;

  always_comb begin
    done_n = done_q;
    err_n  = err_q;
    if (stat_wr && csr_wdata[1]) done_n = 1'b0;
    if (stat_wr && csr_wdata[2]) err_n  = 1'b0;
    if (done_p_i) done_n = 1'b1;
    if (err_p_i)  err_n  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      words_q   <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      irq_o     <= 1'b0;
      csr_rdata <= '0;
    end else begin
      done_q <= done_n;
      err_q  <= err_n;
      irq_o  <= done_n | err_n;
      if (csr_we && csr_addr == CSR_ADDR) addr_q  <= csr_wdata;
      if (csr_we && csr_addr == CSR_LEN)  words_q <= csr_wdata[LEN_W-1:2];
      if (csr_re) begin
        case (csr_addr)
          CSR_ADDR: csr_rdata <= addr_q;
          CSR_LEN:  csr_rdata <= DATA_W'({words_q, 2'b00});
          CSR_STAT: csr_rdata <= DATA_W'({err_q, done_q, busy_i});
          default:  csr_rdata <= '0;
        endcase
      end
    end
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(stat_wr));
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  launch_cfg_t       cfg_i,
  output logic              busy_o,
  output logic              done_p_o,
  output logic              err_p_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              dev_stb_o,
  output logic              dev_we_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic              dev_ack_i,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic              inv_valid_o,
  output logic [ADDR_W-1:0] inv_addr_o
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  xfer_state_e       state_q;
  logic [ADDR_W-1:0] ptr_q, addr_q, next_q;
  logic [1:0]        fidx_q;
  logic [WCNT_W-1:0] words_q, cnt_q;
  logic              to_mem_q, linked_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-PG_W-1:0] seg_page_q;
  logic [LEN_W:0]    seg_end;
  logic              crosses;

  assign seg_end = (LEN_W+1)'(addr_q[PG_W-1:0]) + (LEN_W+1)'({words_q, 2'b00});
  assign crosses = seg_end > (LEN_W+1)'(PAGE_BYTES);

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_DESC) || (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
  assign mem_we_o    = (state_q == ST_MEM_WR);
  assign mem_addr_o  = (state_q == ST_DESC) ? ptr_q + ADDR_W'({fidx_q, 2'b00}) : addr_q;
  assign mem_wdata_o = data_q;
  assign dev_stb_o   = (state_q == ST_DEV_RD) || (state_q == ST_DEV_WR);
  assign dev_we_o    = (state_q == ST_DEV_WR);
  assign dev_wdata_o = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      addr_q      <= '0;
      next_q      <= '0;
      fidx_q      <= '0;
      words_q     <= '0;
      cnt_q       <= '0;
      to_mem_q    <= 1'b0;
      linked_q    <= 1'b0;
      data_q      <= '0;
      seg_page_q  <= '0;
      done_p_o    <= 1'b0;
      err_p_o     <= 1'b0;
      inv_valid_o <= 1'b0;
      inv_addr_o  <= '0;
    end else begin
      done_p_o    <= 1'b0;
      err_p_o     <= 1'b0;
      inv_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (go_i) begin
          linked_q <= cfg_i.linked;
          if (cfg_i.linked) begin
            ptr_q   <= cfg_i.addr;
            fidx_q  <= 2'd0;
            state_q <= ST_DESC;
          end else begin
            addr_q   <= cfg_i.addr;
            to_mem_q <= cfg_i.to_mem;
            words_q  <= cfg_i.words;
            next_q   <= '0;
            state_q  <= ST_CHECK;
          end
        end
        ST_DESC: if (mem_ack_i) begin
          fidx_q <= fidx_q + 2'd1;
          case (fidx_q)
            2'd0: addr_q <= mem_rdata_i;
            2'd1: begin
              to_mem_q <= mem_rdata_i[DATA_W-1];
              words_q  <= mem_rdata_i[LEN_W-1:2];
            end
            default: begin
              next_q  <= mem_rdata_i;
              state_q <= ST_CHECK;
            end
          endcase
        end
        ST_CHECK: begin
          if (words_q == '0 || (linked_q && crosses)) begin
            err_p_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q      <= words_q;
            seg_page_q <= addr_q[ADDR_W-1:PG_W];
            state_q    <= to_mem_q ? ST_DEV_RD : ST_MEM_RD;
          end
        end
        ST_DEV_RD: if (dev_ack_i) begin
          data_q  <= dev_rdata_i;
          state_q <= ST_MEM_WR;
        end
        ST_MEM_WR: if (mem_ack_i) begin
          inv_valid_o <= 1'b1;
          inv_addr_o  <= addr_q;
          addr_q      <= addr_q + ADDR_W'(4);
          cnt_q       <= cnt_q - 1'b1;
          state_q     <= (cnt_q == WCNT_W'(1)) ? ST_NEXT : ST_DEV_RD;
        end
        ST_MEM_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= ST_DEV_WR;
        end
        ST_DEV_WR: if (dev_ack_i) begin
          addr_q  <= addr_q + ADDR_W'(4);
          cnt_q   <= cnt_q - 1'b1;
          state_q <= (cnt_q == WCNT_W'(1)) ? ST_NEXT : ST_MEM_RD;
        end
        ST_NEXT: begin
          if (linked_q && next_q != '0) begin
            ptr_q   <= next_q;
            fidx_q  <= 2'd0;
            state_q <= ST_DESC;
          end else begin
            done_p_o <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  inv_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid_o |-> ($past(mem_req_o && mem_we_o && mem_ack_i) && inv_addr_o == $past(mem_addr_o)));
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R3
  dev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_stb_o && !dev_ack_i) |=> (dev_stb_o && $stable(dev_we_o) && $stable(dev_wdata_o)));
  // R4
  start_from_go_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(go_i));
  // R6
  page_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (linked_q && (state_q == ST_MEM_WR || state_q == ST_MEM_RD)) |-> (mem_addr_o[ADDR_W-1:PG_W] == seg_page_q));
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [1:0]        csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dev_stb,
  output logic              dev_we,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              inv_valid,
  output logic [ADDR_W-1:0] inv_addr
);
  logic        go, busy, done_p, err_p;
  launch_cfg_t cfg;

  chain_dma_regs u_regs (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .busy_i(busy), .done_p_i(done_p), .err_p_i(err_p),
    .go_o(go), .cfg_o(cfg), .irq_o(irq)
  );

  chain_dma_engine #(.PAGE_BYTES(PAGE_BYTES)) u_engine (
    .clk(clk), .rst(rst), .go_i(go), .cfg_i(cfg),
    .busy_o(busy), .done_p_o(done_p), .err_p_o(err_p),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dev_stb_o(dev_stb), .dev_we_o(dev_we), .dev_wdata_o(dev_wdata),
    .dev_ack_i(dev_ack), .dev_rdata_i(dev_rdata),
    .inv_valid_o(inv_valid), .inv_addr_o(inv_addr)
  );
endmodule

// File: tb/test_chain_dma.sv
`timescale 1ns/1ps
module test_chain_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [1:0]  csr_addr = 2'd0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        irq, mem_req, mem_we, dev_stb, dev_we, inv_valid;
  logic [31:0] mem_addr, mem_wdata, dev_wdata, inv_addr;
  logic        mem_ack = 1'b0, dev_ack = 1'b0;
  logic [31:0] mem_rdata = '0, dev_rdata = '0;

  logic [31:0] mem  [0:4095];
  logic [31:0] sink [0:63];
  logic [31:0] wr_log [0:63];
  int wr_cnt, rd_cnt, inv_cnt, inv_bad, src_cnt, sink_cnt;
  logic [31:0] src_base;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  chain_dma i_chain_dma (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_stb(dev_stb), .dev_we(dev_we), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  // memory, peripheral and invalidate models, active on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      dev_ack <= 1'b0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[13:2]] = mem_wdata;
          if (wr_cnt < 64) wr_log[wr_cnt] = mem_addr;
          wr_cnt++;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
          rd_cnt++;
        end
      end else mem_ack <= 1'b0;
      if (dev_stb && !dev_ack) begin
        dev_ack <= 1'b1;
        if (dev_we) begin
          if (sink_cnt < 64) sink[sink_cnt] = dev_wdata;
          sink_cnt++;
        end else begin
          dev_rdata <= src_base + 32'(src_cnt);
          src_cnt++;
        end
      end else dev_ack <= 1'b0;
      if (inv_valid) begin
        if (inv_cnt >= 64 || inv_cnt >= wr_cnt || wr_log[inv_cnt] != inv_addr) inv_bad++;
        inv_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_logs(input logic [31:0] base);
    wr_cnt = 0; rd_cnt = 0; inv_cnt = 0; inv_bad = 0;
    src_cnt = 0; sink_cnt = 0; src_base = base;
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_re = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_re = 1'b0;
    d = csr_rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      seen = irq;
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] lw, input logic [31:0] nx);
    mem[at/4] = a; mem[at/4+1] = lw; mem[at/4+2] = nx;
  endtask

  task automatic clear_status();
    csr_write(2'd3, 32'h6);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    csr_read(2'd3, s);
    chk(s == 32'h0, "R1 status after reset", s, 32'h0);
    chk(irq == 1'b0 && mem_req == 1'b0 && dev_stb == 1'b0, "R1 quiet outputs",
        {29'b0, irq, mem_req, dev_stb}, 32'h0);
  endtask

  task automatic t_direct_to_mem();
    logic [31:0] s; bit seen; int bad = 0;
    clr_logs(32'hA000_0000);
    csr_write(2'd1, 32'h100);
    csr_write(2'd2, 32'd64);
    csr_write(2'd0, 32'h5);
    csr_read(2'd3, s);
    chk(s[0] == 1'b1, "R4 busy during transfer", s, 32'h1);
    wait_irq(seen);
    chk(seen, "R9 irq after direct write", {31'b0, seen}, 32'h1);
    for (int i = 0; i < 16; i++) if (mem[32'h40 + i] != 32'hA000_0000 + i) bad++;
    chk(bad == 0, "R2 data placed", bad, 0);
    chk(wr_cnt == 16, "R2 word count", wr_cnt, 16);
    chk(inv_cnt == 16 && inv_bad == 0, "R8 invalidate per write", inv_cnt, 16);
    csr_read(2'd3, s);
    chk(s == 32'h2, "R10 status done", s, 32'h2);
    clear_status();
    chk(irq == 1'b0, "R9 irq cleared by status write", irq, 0);
    csr_read(2'd3, s);
    chk(s == 32'h0, "R9 status cleared", s, 32'h0);
  endtask

  task automatic t_direct_to_dev();
    bit seen; int bad = 0;
    clr_logs(32'h0);
    for (int i = 0; i < 8; i++) mem[32'h800 + i] = 32'h5000 + 32'(i * 3);
    csr_write(2'd1, 32'h2000);
    csr_write(2'd2, 32'd32);
    csr_write(2'd0, 32'h1);
    wait_irq(seen);
    chk(seen, "R3 irq", {31'b0, seen}, 32'h1);
    for (int i = 0; i < 8; i++) if (sink[i] != 32'h5000 + 32'(i * 3)) bad++;
    chk(bad == 0 && sink_cnt == 8, "R3 device received data", sink_cnt, 8);
    chk(wr_cnt == 0 && inv_cnt == 0, "R8 no invalidate on reads", inv_cnt, 0);
    clear_status();
  endtask

  task automatic t_chain_scatter();
    logic [31:0] s; bit seen; int bad = 0;
    clr_logs(32'hC000_0000);
    put_desc(32'h3000, 32'h0F80, 32'h8000_0080, 32'h3010);
    put_desc(32'h3010, 32'h2400, 32'h8000_0010, 32'h3020);
    put_desc(32'h3020, 32'h1010, 32'h8000_0008, 32'h0);
    csr_write(2'd1, 32'h3000);
    csr_write(2'd0, 32'h3);
    wait_irq(seen);
    for (int i = 0; i < 32; i++) if (mem[32'h3E0 + i] != 32'hC000_0000 + i) bad++;
    for (int i = 0; i < 4; i++)  if (mem[32'h900 + i] != 32'hC000_0020 + i) bad++;
    for (int i = 0; i < 2; i++)  if (mem[32'h404 + i] != 32'hC000_0024 + i) bad++;
    chk(bad == 0, "R5 scattered segments placed", bad, 0);
    chk(wr_cnt == 38, "R6 segment ending on page boundary accepted", wr_cnt, 38);
    chk(inv_cnt == 38 && inv_bad == 0, "R8 invalidates in linked mode", inv_cnt, 38);
    csr_read(2'd3, s);
    chk(s == 32'h2, "R5 list done", s, 32'h2);
    clear_status();
  endtask

  task automatic t_chain_cross();
    logic [31:0] s; bit seen;
    clr_logs(32'hD000_0000);
    put_desc(32'h3100, 32'h1800, 32'h8000_0010, 32'h3110);
    put_desc(32'h3110, 32'h0FF8, 32'h8000_0010, 32'h0);
    csr_write(2'd1, 32'h3100);
    csr_write(2'd0, 32'h3);
    wait_irq(seen);
    chk(seen, "R6 irq on bad segment", {31'b0, seen}, 32'h1);
    chk(wr_cnt == 4 && src_cnt == 4, "R6 no access for crossing segment", wr_cnt, 4);
    csr_read(2'd3, s);
    chk(s == 32'h4, "R6 error status", s, 32'h4);
    clear_status();
  endtask

  task automatic t_zero_len();
    logic [31:0] s; bit seen;
    clr_logs(32'h0);
    csr_write(2'd1, 32'h400);
    csr_write(2'd2, 32'd0);
    csr_write(2'd0, 32'h5);
    wait_irq(seen);
    csr_read(2'd3, s);
    chk(s == 32'h4, "R7 zero length error", s, 32'h4);
    chk(wr_cnt == 0 && rd_cnt == 0 && src_cnt == 0, "R7 no data access", wr_cnt + src_cnt, 0);
    clear_status();
  endtask

  task automatic t_start_while_busy();
    bit seen;
    clr_logs(32'hE000_0000);
    csr_write(2'd1, 32'h200);
    csr_write(2'd2, 32'd40);
    csr_write(2'd0, 32'h5);
    csr_write(2'd1, 32'h600);
    csr_write(2'd0, 32'h5);
    wait_irq(seen);
    chk(wr_cnt == 10 && wr_log[9] == 32'h224, "R4 second start ignored", wr_cnt, 10);
    clear_status();
    repeat (100) @(negedge clk);
    chk(irq == 1'b0 && wr_cnt == 10, "R4 no second completion", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_chain_to_dev();
    bit seen; int bad = 0;
    clr_logs(32'h0);
    for (int i = 0; i < 3; i++) mem[32'hA00 + i] = 32'h7700 + i;
    put_desc(32'h3200, 32'h2800, 32'h0000_000C, 32'h0);
    csr_write(2'd1, 32'h3200);
    csr_write(2'd0, 32'h3);
    wait_irq(seen);
    for (int i = 0; i < 3; i++) if (sink[i] != 32'h7700 + i) bad++;
    chk(bad == 0 && sink_cnt == 3, "R5 direction bit selects memory to device", sink_cnt, 3);
    clear_status();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    clr_logs(32'h0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct_to_mem();
    t_direct_to_dev();
    t_chain_scatter();
    t_chain_cross();
    t_zero_len();
    t_start_while_busy();
    t_chain_to_dev();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule